// File: doc/BRIEF.md
# Fault-Tolerant Clock Resynchronization Unit

This block keeps a free-running local time counter aligned with a group of N clocks: itself and N-1 peers. When the peer values are presented with a strobe, the unit snapshots its own count, the peer values and the rejection threshold. It then walks the peers one per cycle, forming each peer's difference from the snapshot as peer minus own. A difference whose magnitude is at or above the threshold is treated as coming from a broken or wildly drifting clock. It contributes zero and is counted as excluded.

When the walk is finished, the accepted differences are summed and divided by the full clock count N, not by the number of clocks that were accepted. The own clock's term is always zero. The quotient is added to the counter in one cycle. The counter keeps ticking during the computation, so those ticks are kept as well. A single-cycle completion pulse reports the correction that was applied and the number of peers that were excluded.

The controller has three states. ST_IDLE leaves for ST_ACCUM when a strobe arrives (transition "accept"). ST_ACCUM stays put while peers remain ("step"). It leaves for ST_APPLY after the last peer ("last"). ST_APPLY always returns to ST_IDLE ("commit").

Top module: `resync_core`

## Requirements
- R1: During reset `time_out` is 0 and `done` is 0.
- R2: Outside the apply cycle, `time_out` increases by exactly 1 every clock, wrapping modulo 2^W.
- R3: A strobe in ST_IDLE captures `time_out`, every peer value and `limit` at that edge. Each peer's difference is (peer − captured own) in W-bit two's complement. Peer k occupies bits [k*W +: W] of `peer_bus`.
- R4: A difference is accepted only when its magnitude is strictly below `limit`, compared as an unsigned value. A magnitude equal to `limit` is excluded, and `limit` = 0 excludes every peer.
- R5: `corr_out` equals the signed sum of the accepted differences divided by N, truncated toward zero. The divisor is always N, however many peers were excluded.
- R6: `done` is high for exactly one cycle, P+1 cycles after the accepting edge, where P = N−1. While it is high, `time_out` equals the captured value plus P+1.
- R7: On the edge that ends the `done` cycle, `time_out` becomes its previous value + 1 + `corr_out`.
- R8: A strobe that arrives while ST_ACCUM or ST_APPLY is active is ignored. It produces no extra `done` and does not change the result in progress.
- R9: While `done` is high, `excl_out` gives the number of peers excluded in that epoch, from 0 to P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| peer_bus | input | (N-1)*W | Peer clock values; peer k at bits [k*W +: W] |
| peer_vld | input | 1 | Strobe: peer values are current |
| limit | input | W | Rejection threshold on the difference magnitude |
| time_out | output | W | Adjusted local time |
| done | output | 1 | One-cycle pulse when the correction is applied |
| corr_out | output | W | Signed correction applied (valid with done) |
| excl_out | output | $clog2(N) | Excluded peer count (valid with done) |

## Verification
Equal positive offsets and equal negative offsets show the averaging and its truncation toward zero in both directions. A mix of near and far peers, with offsets exactly at the limit and one below it, separates the strict comparison from a non-strict one. Two far peers alongside two equal near ones show whether the divisor is N or the accepted count. A zero limit and an all-pass limit cover the extremes of exclusion, and a second strobe with different values during a computation shows that a busy unit ignores it.

// File: rtl/resync_pkg.sv
package resync_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_APPLY = 2'd2
    } rs_state_e;

    // Unsigned magnitude of a 32-bit two's complement value; the most
    // negative value maps to 2^31 without overflow.
    function automatic logic [31:0] mag32(input logic [31:0] v);
        return v[31] ? (~v + 32'd1) : v;
    endfunction

endpackage

// File: rtl/resync_timebase.sv
module resync_timebase #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         apply_en,
    input  logic [W-1:0] adj,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (apply_en)
            cnt <= cnt + W'(1) + adj;
        else
            cnt <= cnt + W'(1);
    end

    assert_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_en |=> cnt == $past(cnt) + W'(1));

    assert_apply_R7: assert property (@(posedge clk) disable iff (!rst_n)
        apply_en |=> cnt == $past(cnt) + W'(1) + $past(adj));
endmodule

// File: rtl/resync_term.sv
module resync_term #(
    parameter int W = 32
) (
    input  logic [W-1:0] peer,
    input  logic [W-1:0] own,
    input  logic [W-1:0] thr,
    output logic [W-1:0] diff,
    output logic         accept
);
    logic [W-1:0] mag;

    always_comb begin
        diff   = peer - own;
        mag    = diff[W-1] ? (~diff + W'(1)) : diff;
        accept = (mag < thr);
    end
endmodule

// File: rtl/resync_accum.sv
module resync_accum #(
    parameter int W  = 32,
    parameter int SW = 36,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [W-1:0]  diff,
    input  logic          accept,
    output logic [SW-1:0] sum,
    output logic [CW-1:0] excl
);
    logic [SW-1:0] diff_ext;

    always_comb diff_ext = {{(SW-W){diff[W-1]}}, diff};

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sum  <= '0;
            excl <= '0;
        end else if (step) begin
            if (accept)
                sum <= sum + diff_ext;
            else
                excl <= excl + CW'(1);
        end
    end
endmodule

// File: rtl/resync_core.sv
module resync_core #(
    parameter int N = 5,
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [(N-1)*W-1:0]   peer_bus,
    input  logic                 peer_vld,
    input  logic [W-1:0]         limit,
    output logic [W-1:0]         time_out,
    output logic                 done,
    output logic [W-1:0]         corr_out,
    output logic [$clog2(N)-1:0] excl_out
);
    import resync_pkg::*;

    localparam int P  = N - 1;
    localparam int IW = (P > 1) ? $clog2(P) : 1;
    localparam int CW = $clog2(N);
    localparam int SW = W + $clog2(N) + 1;
    localparam logic signed [SW-1:0] NDIV = SW'(N);

    rs_state_e     state, state_nx;
    logic [W-1:0]  own_snap;
    logic [W-1:0]  thr_q;
    logic [W-1:0]  peer_q [P];
    logic [IW-1:0] idx;
    logic          last_peer;

    logic [W-1:0]  cur_diff;
    logic          cur_accept;
    logic [SW-1:0] sum;
    logic [CW-1:0] excl;
    logic signed [SW-1:0] quo;
    logic          apply_en;
    logic          accum_clear;
    logic          accum_step;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb last_peer = (idx == IW'(P - 1));

    // transitions: accept, step, last, commit
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (peer_vld) state_nx = ST_ACCUM;
            ST_ACCUM: if (last_peer) state_nx = ST_APPLY;
            ST_APPLY: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // capture on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_snap <= '0;
            thr_q    <= '0;
        end else if (state == ST_IDLE && peer_vld) begin
            own_snap <= time_out;
            thr_q    <= limit;
        end
    end

    generate
        for (genvar k = 0; k < P; k++) begin : g_peer
            always_ff @(posedge clk) begin
                if (!rst_n)
                    peer_q[k] <= '0;
                else if (state == ST_IDLE && peer_vld)
                    peer_q[k] <= peer_bus[k*W +: W];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (state == ST_ACCUM)
            idx <= last_peer ? '0 : idx + IW'(1);
        else
            idx <= '0;
    end

    resync_term #(.W(W)) i_term (
        .peer   (peer_q[idx]),
        .own    (own_snap),
        .thr    (thr_q),
        .diff   (cur_diff),
        .accept (cur_accept)
    );

    resync_accum #(.W(W), .SW(SW), .CW(CW)) i_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accum_clear),
        .step   (accum_step),
        .diff   (cur_diff),
        .accept (cur_accept),
        .sum    (sum),
        .excl   (excl)
    );

    always_comb quo = $signed(sum) / NDIV;

    // outputs
    always_comb begin
        done        = 1'b0;
        apply_en    = 1'b0;
        accum_clear = 1'b0;
        accum_step  = 1'b0;
        corr_out    = '0;
        excl_out    = '0;
        unique case (state)
            ST_IDLE:  accum_clear = 1'b1;
            ST_ACCUM: accum_step  = 1'b1;
            ST_APPLY: begin
                done     = 1'b1;
                apply_en = 1'b1;
                corr_out = quo[W-1:0];
                excl_out = excl;
            end
            default: ;
        endcase
    end

    resync_timebase #(.W(W)) i_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply_en (apply_en),
        .adj      (corr_out),
        .cnt      (time_out)
    );

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_excl_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> excl_out <= CW'(P));

    assert_corr_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && corr_out != '0) |-> corr_out[W-1] == sum[SW-1]);

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCUM) |=> ($stable(own_snap) && $stable(thr_q)));
endmodule

// File: tb/test_resync_core.sv
module test_resync_core;
    localparam int N  = 5;
    localparam int W  = 32;
    localparam int P  = N - 1;
    localparam int CW = $clog2(N);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [P*W-1:0]       peer_bus = '0;
    logic                 peer_vld = 1'b0;
    logic [W-1:0]         limit = '0;
    logic [W-1:0]         time_out;
    logic                 done;
    logic [W-1:0]         corr_out;
    logic [CW-1:0]        excl_out;

    always #4 clk = ~clk;

    resync_core #(.N(N), .W(W)) i_resync_core (
        .clk(clk), .rst_n(rst_n), .peer_bus(peer_bus), .peer_vld(peer_vld),
        .limit(limit), .time_out(time_out), .done(done),
        .corr_out(corr_out), .excl_out(excl_out)
    );

    typedef struct {
        logic [W-1:0] start;
        logic [W-1:0] corr;
        logic [W-1:0] excl;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int total = 0;
    int bad = 0;
    int dones = 0;
    int pushed = 0;

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic epoch(string tag, input logic [W-1:0] thr, input int off [P], input bit junk);
        logic [W-1:0] c;
        longint s;
        int ex;
        longint m;
        exp_t e;
        @(negedge clk);
        limit = thr;
        c = time_out;
        s = 0;
        ex = 0;
        for (int k = 0; k < P; k++) begin
            peer_bus[k*W +: W] = W'(longint'(c) + longint'(off[k]));
            m = (off[k] < 0) ? -longint'(off[k]) : longint'(off[k]);
            if (m < longint'(thr)) s += off[k];
            else ex++;
        end
        e.start = c;
        e.corr  = W'(s / N);
        e.excl  = W'(ex);
        e.tag   = tag;
        sb.push_back(e);
        pushed++;
        peer_vld = 1'b1;
        @(negedge clk);
        peer_vld = 1'b0;
        if (junk) begin
            @(negedge clk);
            for (int k = 0; k < P; k++) peer_bus[k*W +: W] = W'(32'h5000_0000 + k);
            peer_vld = 1'b1;
            @(negedge clk);
            peer_vld = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                dones++;
                if (sb.size() == 0) begin
                    check("R8 unexpected done", 32'd1, 32'd0);
                end else begin
                    e = sb.pop_front();
                    check({"R5 corr ", e.tag}, corr_out, e.corr);
                    check({"R9 excl ", e.tag}, W'(excl_out), e.excl);
                    check({"R6 latency ", e.tag}, time_out, e.start + W'(P + 1));
                    @(negedge clk);
                    check({"R7 applied ", e.tag}, time_out, e.start + W'(P + 2) + e.corr);
                    check({"R6 single pulse ", e.tag}, W'(done), 32'd0);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R6 watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] a;
        repeat (3) @(negedge clk);
        check("R1 time reset", time_out, 32'd0);
        check("R1 done reset", W'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        a = time_out;
        @(negedge clk);
        check("R2 tick", time_out, a + 32'd1);

        epoch("R3 equal positive", 32'd100, '{10, 10, 10, 10}, 1'b0);
        epoch("R5 negative trunc", 32'd100, '{-7, -7, -7, -7}, 1'b0);
        epoch("R4 outliers", 32'd100, '{20, -3, 1000, -5000}, 1'b0);
        epoch("R4 boundary", 32'd100, '{100, 99, -100, -99}, 1'b0);
        epoch("R4 zero limit", 32'd0, '{1, -1, 0, 5}, 1'b0);
        epoch("R5 full divisor", 32'd100, '{50, 50, 9999, -9999}, 1'b0);
        epoch("R4 all pass", 32'hFFFF_FFFF, '{3, 3, 3, 3}, 1'b0);
        epoch("R8 busy strobe", 32'd100, '{-40, 12, 8, 30}, 1'b1);

        repeat (10) @(negedge clk);
        check("R8 done count", W'(dones), W'(pushed));
        check("R8 queue empty", W'(sb.size()), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule